// File: doc/BRIEF.md
# FSK Carrier Detect Qualifier

This block decides when the receive path of an FSK caller-identity front end is carrying a real carrier. Each clock cycle it takes a one-bit activity flag that an upstream energy detector raises when the FSK bandpass filter output holds enough in-band signal. Activity has to last, without a break, for a programmable qualification interval before the block declares carrier present. It then drives its active-low carrier-detect output low and raises a carrier-valid enable.

Once carrier is declared, short dropouts in the activity flag are bridged. Carrier is withdrawn only after a hangover of 8 ms with no activity at all, and the hangover length is computed from the system clock frequency parameter. The carrier-valid enable gates the whole data path. While it is low, the demodulated bit passed downstream is held at the idle mark level, so the data timing recovery sees no transitions. A low FSK enable input or a high power-down input removes carrier at once and discards any partial qualification or hangover progress. This keeps speech, alert tones and DTMF from producing words while no FSK is expected.

Top module: `fsk_carrier_qual`

## Requirements
- R1: While the synchronous active-low reset is applied, and at the first cycle after it is released, `cd_n_o` is 1, `valid_o` is 0 and `data_o` is 1.
- R2: `cd_n_o` goes low after the clock edge that samples the QUAL_CYC-th consecutive cycle with `act_i` high, and not before.
- R3: A cycle with `act_i` low during qualification restarts the count, so QUAL_CYC further consecutive active cycles are needed.
- R4: Once `cd_n_o` is low, any run of fewer than HANG_CYC consecutive inactive cycles leaves it low, and each active cycle restarts the hangover.
- R5: `cd_n_o` returns high after the clock edge that samples the HANG_CYC-th consecutive cycle with `act_i` low, where HANG_CYC = CLK_HZ*8/1000 (8 ms).
- R6: `valid_o` is always the complement of `cd_n_o`.
- R7: `data_o` equals `demod_i` while `valid_o` is 1 and is held at 1 (mark) while `valid_o` is 0.
- R8: With `fsk_en_i` low, `cd_n_o` is 1 in the same cycle and both counts are cleared, so full qualification is needed after enable returns.
- R9: With `pdn_i` high, `cd_n_o` is 1 in the same cycle and both counts are cleared, as for R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| act_i | input | 1 | Per-cycle in-band activity flag from the filter level detector |
| demod_i | input | 1 | Raw demodulator bit |
| fsk_en_i | input | 1 | FSK enable; low suppresses carrier and data |
| pdn_i | input | 1 | Power-down, active high |
| cd_n_o | output | 1 | Carrier detect, active low |
| valid_o | output | 1 | Carrier-valid enable for data recovery |
| data_o | output | 1 | Gated demodulated bit, 1 when carrier is invalid |

## Verification
The activity flag is driven with bursts one cycle short of the qualification length and then exactly at that length. This separates an off-by-one in qualification from correct assertion. A burst broken by one idle cycle shows whether the count restarts or merely pauses. With carrier held, gaps of HANG_CYC-1 and HANG_CYC cycles locate the release edge exactly, and a single active cycle between gaps shows that the hangover is rearmed. Enable and power-down pulses are applied both during qualification and while carrier is held, followed by a burst one cycle short of qualification, which shows that the counts were cleared rather than frozen. A toggling demodulator bit throughout checks the data gating in every state.

// File: rtl/cdq_pkg.sv
// Shared helpers for the carrier detect qualifier.
// Assumes clock frequencies given in Hz and intervals in milliseconds.
package cdq_pkg;

    // Number of clock cycles in a given number of milliseconds.
    function automatic int unsigned ms_to_cycles(input int unsigned clk_hz,
                                                 input int unsigned ms);
        longint unsigned prod;
        prod = longint'(clk_hz) * longint'(ms);
        return int'(prod / 1000);
    endfunction

    // Counter width able to hold the value `limit`.
    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/cdq_run_counter.sv
// Counts consecutive cycles on which `inc_i` is high.
// `clr_i` has priority and zeroes the count. `hit_o` flags the cycle
// whose increment would complete LIMIT consecutive counts.
// Assumes LIMIT >= 1 and that the caller clears the count after a hit.
module cdq_run_counter #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic hit_o
);
    localparam int unsigned W = cdq_pkg::cnt_width(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    // Run length register: cleared on reset or request, else counts.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Terminal count flag for the current increment.
    always_comb begin
        hit_o = inc_i && !clr_i && (cnt_q == LAST);
    end

endmodule

// File: rtl/cdq_gate.sv
// Output stage: forces carrier off at once when the path is not running,
// derives the enable and holds the data bit at mark while invalid.
// Assumes `active_i` is the registered carrier state.
module cdq_gate (
    input  logic active_i,
    input  logic run_i,
    input  logic demod_i,
    output logic cd_n_o,
    output logic valid_o,
    output logic data_o
);
    logic valid;

    // Combinational gating so enable and power-down act in the same cycle.
    always_comb begin
        valid   = active_i && run_i;
        valid_o = valid;
        cd_n_o  = !valid;
        data_o  = valid ? demod_i : 1'b1;
    end

endmodule

// File: rtl/fsk_carrier_qual.sv
// Carrier detect qualifier for an FSK receive path.
// Declares carrier after QUAL_CYC consecutive active cycles, holds it
// through gaps and releases it after an 8 ms hangover derived from CLK_HZ.
// Assumes `act_i` is synchronous to `clk`; reset is synchronous, active low.
module fsk_carrier_qual #(
    parameter int unsigned CLK_HZ   = 3579545,
    parameter int unsigned QUAL_CYC = 14318
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic demod_i,
    input  logic fsk_en_i,
    input  logic pdn_i,
    output logic cd_n_o,
    output logic valid_o,
    output logic data_o
);
    localparam int unsigned HANG_CYC = cdq_pkg::ms_to_cycles(CLK_HZ, 8);

    logic run;
    logic active_q;
    logic qual_clr, qual_inc, qual_hit;
    logic hang_clr, hang_inc, hang_hit;

    // Path runs only when enabled and powered.
    always_comb begin
        run = fsk_en_i && !pdn_i;
    end

    // Counter controls: qualify while idle, time gaps while active.
    always_comb begin
        qual_inc = run && act_i && !active_q;
        qual_clr = !run || !act_i || active_q;
        hang_inc = run && !act_i && active_q;
        hang_clr = !run || act_i || !active_q;
    end

    cdq_run_counter #(.LIMIT(QUAL_CYC)) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (qual_clr),
        .inc_i (qual_inc),
        .hit_o (qual_hit)
    );

    cdq_run_counter #(.LIMIT(HANG_CYC)) u_hang (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (hang_clr),
        .inc_i (hang_inc),
        .hit_o (hang_hit)
    );

    // Carrier state: set on qualification, cleared on hangover or stop.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            active_q <= 1'b0;
        end else if (!active_q && qual_hit) begin
            active_q <= 1'b1;
        end else if (active_q && hang_hit) begin
            active_q <= 1'b0;
        end
    end

    cdq_gate u_gate (
        .active_i (active_q),
        .run_i    (run),
        .demod_i  (demod_i),
        .cd_n_o   (cd_n_o),
        .valid_o  (valid_o),
        .data_o   (data_o)
    );

endmodule

// File: rtl/cdq_checker.sv
// Protocol checks for fsk_carrier_qual, attached by bind.
// Assumes synchronous active-low reset on the same clock.
module cdq_checker (
    input logic clk,
    input logic rst_n,
    input logic act_i,
    input logic fsk_en_i,
    input logic pdn_i,
    input logic cd_n_o,
    input logic valid_o,
    input logic data_o
);
    logic run;
    assign run = fsk_en_i && !pdn_i;

    AST_ASSERT_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cd_n_o) |-> $past(act_i));                              // R2

    AST_HOLD_ON_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cd_n_o && act_i && run) |=> (!run || !cd_n_o));             // R4

    AST_RELEASE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cd_n_o) && run) |-> !$past(act_i));                    // R5

    AST_VALID_MATCHES_CD: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o != cd_n_o);                                           // R6

    AST_DATA_MARK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> data_o);                                         // R7

    AST_EN_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !fsk_en_i |-> cd_n_o);                                        // R8

    AST_PDN_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        pdn_i |-> cd_n_o);                                            // R9

endmodule

bind fsk_carrier_qual cdq_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_i    (act_i),
    .fsk_en_i (fsk_en_i),
    .pdn_i    (pdn_i),
    .cd_n_o   (cd_n_o),
    .valid_o  (valid_o),
    .data_o   (data_o)
);

// File: tb/sim_fsk_carrier_qual.sv
// Scoreboard bench: the driver pushes expected outputs, the monitor compares.
module sim_fsk_carrier_qual;
    localparam int unsigned CLK_HZ = 2000;
    localparam int unsigned QUAL   = 10;
    localparam int unsigned HANG   = CLK_HZ * 8 / 1000;   // 16

    typedef struct {
        logic  cd_n;
        logic  valid;
        logic  data;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic act = 1'b0, dm = 1'b0, en = 1'b1, pd = 1'b0;
    logic cd_n, valid, data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    exp_t q[$];

    // Reference state built from the requirements.
    bit m_active = 1'b0;
    int m_run = 0;
    int m_gap = 0;

    always #2.5 clk = ~clk;

    fsk_carrier_qual #(.CLK_HZ(CLK_HZ), .QUAL_CYC(QUAL)) u0 (
        .clk(clk), .rst_n(rst_n), .act_i(act), .demod_i(dm),
        .fsk_en_i(en), .pdn_i(pd), .cd_n_o(cd_n), .valid_o(valid), .data_o(data)
    );

    // Drive one cycle, queue the expectation, advance the model.
    task automatic tick(input logic a, input logic r, input logic e,
                        input logic p, input string tag);
        exp_t x;
        bit vis;
        @(negedge clk);
        act = a; rst_n = r; en = e; pd = p; dm = ~dm;
        vis = m_active && e && !p;
        x.cd_n = !vis; x.valid = vis; x.data = vis ? dm : 1'b1; x.tag = tag;
        q.push_back(x);
        if (!r || !e || p) begin
            m_active = 0; m_run = 0; m_gap = 0;
        end else if (!m_active) begin
            m_gap = 0;
            if (a) begin
                m_run++;
                if (m_run == QUAL) begin m_active = 1; m_run = 0; end
            end else m_run = 0;
        end else begin
            m_run = 0;
            if (a) m_gap = 0;
            else begin
                m_gap++;
                if (m_gap == HANG) begin m_active = 0; m_gap = 0; end
            end
        end
    endtask

    task automatic ticks(input int n, input logic a, input string tag);
        for (int i = 0; i < n; i++) tick(a, 1'b1, 1'b1, 1'b0, tag);
    endtask

    // Monitor: compares outputs after inputs settle.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t x;
                x = q.pop_front();
                total++;
                if (cd_n !== x.cd_n || valid !== x.valid || data !== x.data) begin
                    bad++;
                    $display("FAIL %s cd_n/valid/data=%b%b%b expected %b%b%b",
                             x.tag, cd_n, valid, data, x.cd_n, x.valid, x.data);
                end
            end
        end
    end

    // Stimulus.
    initial begin
        for (int i = 0; i < 4; i++) tick(1'b1, 1'b0, 1'b1, 1'b0, "R1 reset");
        ticks(2, 1'b0, "R1 after reset");
        ticks(QUAL - 1, 1'b1, "R2 short burst");
        ticks(1, 1'b0, "R3 break");
        ticks(QUAL - 1, 1'b1, "R3 restart");
        ticks(1, 1'b0, "R3 break again");
        ticks(QUAL, 1'b1, "R2 qualify");
        ticks(3, 1'b1, "R2 asserted R6 R7");
        ticks(HANG - 1, 1'b0, "R4 gap short");
        ticks(1, 1'b1, "R4 rearm");
        ticks(HANG - 1, 1'b0, "R4 second gap");
        ticks(1, 1'b0, "R5 hangover end");
        ticks(3, 1'b0, "R5 released");
        ticks(QUAL + 2, 1'b1, "R2 requalify");
        tick(1'b1, 1'b1, 1'b0, 1'b0, "R8 enable low");
        ticks(QUAL - 1, 1'b1, "R8 counts cleared");
        ticks(3, 1'b1, "R8 requalified");
        tick(1'b1, 1'b1, 1'b1, 1'b1, "R9 power down");
        tick(1'b1, 1'b1, 1'b1, 1'b1, "R9 power down");
        ticks(QUAL - 1, 1'b1, "R9 counts cleared");
        ticks(2, 1'b1, "R9 requalified");
        ticks(HANG - 2, 1'b0, "R9 gap");
        tick(1'b0, 1'b1, 1'b1, 1'b1, "R9 clears hang");
        ticks(QUAL - 2, 1'b1, "R8 idle after pdn");
        ticks(HANG, 1'b0, "R5 stays off");
        tick(1'b0, 1'b0, 1'b1, 1'b0, "R1 late reset");
        ticks(2, 1'b0, "R1 after late reset");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog.
    initial begin
        #100000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule